// File: doc/BRIEF.md
# Seat Belt Reminder Controller

This controller decides when a vehicle's seat-belt reminder should sound. It watches a key-on level, a belt-fastened level and a one-cycle pulse that arrives once per second. It drives two outputs: an alarm enable and a one-cycle strobe that marks the start of the grace timer. Sound generation and input debouncing are handled elsewhere. The whole block runs in one clock domain and uses a synchronous reset.

Turning the key on starts a grace period, counted in seconds pulses. If the belt is still open when the grace period ends, the alarm sounds for a bounded number of seconds. The alarm stops early if the belt is fastened or the key is turned off. Once the reminder has been served, either by fastening the belt or by the alarm running out, the controller stays quiet until the key goes off and comes back on.

The control core has three states: Off, Wait and Alarm. A hold flag inside Off records that the key is still on after the reminder was served. A single seconds counter is shared by the grace phase and the alarm phase. It clears whenever the state changes.

Top module: `belt_chime_ctrl`

## Requirements
- R1: During and right after reset, `alarm_en` and `timer_start` are both 0, and the controller is idle in Off.
- R2: When `key_on` is high in idle Off, `timer_start` is 1 for exactly the one cycle after the cycle in which `key_on` was sampled high, and the controller enters Wait.
- R3: In Wait, with the key on and the belt open, `alarm_en` becomes 1 in the cycle after the GRACE_SEC-th seconds pulse counted in Wait.
- R4: Key-off during Wait returns to idle Off. Later seconds pulses do not raise the alarm, and a new key-on gives a new `timer_start` strobe.
- R5: Fastening the belt while `alarm_en` is 1 clears `alarm_en` in the next cycle.
- R6: Key-off while `alarm_en` is 1 clears `alarm_en` in the next cycle.
- R7: `alarm_en` clears in the cycle after the ALARM_SEC-th seconds pulse counted in Alarm.
- R8: Fastening the belt in Wait cancels the pending alarm. Opening the belt again while the key stays on neither re-arms the alarm nor produces `timer_start`.
- R9: Only cycles with `sec_tick` = 1 advance time. The count restarts from zero on every entry to Wait or Alarm.
- R10: After the alarm ends by timeout or belt while the key stays on, no strobe and no alarm occur until the key goes low and then high again.
- R11: If key-off and the final grace pulse fall in the same cycle, key-off wins and no alarm occurs.
- R12: `timer_start` and `alarm_en` are never 1 in the same cycle, and `alarm_en` only rises in the cycle after a seconds pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_on | input | 1 | Ignition key level, 1 = on |
| belt_fastened | input | 1 | Belt level, 1 = fastened |
| sec_tick | input | 1 | One-cycle pulse once per second |
| alarm_en | output | 1 | Alarm sound enable |
| timer_start | output | 1 | One-cycle strobe on grace timer start |

## Verification
The main function is driven through four groups of stimulus. In the first, the belt is never fastened, so the grace timeout and the alarm timeout are reached back to back. In the second, the belt is fastened during Wait and during Alarm, which separates cancellation from early termination. In the third, the key is dropped during Wait, during Alarm and in the same cycle as the final pulse, which checks that key-off takes priority. In the fourth, long gaps without pulses and key cycles in the middle of the grace period show that only pulses are counted and that the count restarts on each entry.

// File: rtl/belt_pkg.sv
package belt_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ALARM = 2'd2
  } belt_state_e;

  // True when one more pulse completes a window of `limit` seconds.
  function automatic logic last_second(logic [15:0] count, logic [15:0] limit);
    return (count + 16'd1) >= limit;
  endfunction
endpackage

// File: rtl/belt_sec_counter.sv
module belt_sec_counter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [15:0]   limit,
  output logic          done
);
  import belt_pkg::*;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = tick && last_second(16'(cnt_q), limit);
endmodule

// File: rtl/belt_fsm.sv
module belt_fsm (
  input  logic                  state_is_hold,
  input  belt_pkg::belt_state_e state_q,
  input  logic                  key_on,
  input  logic                  belt_fastened,
  input  logic                  window_done,
  output belt_pkg::belt_state_e state_d,
  output logic                  hold_d,
  output logic                  ev_start,
  output logic                  ev_grace_done,
  output logic                  ev_alarm_done,
  output logic                  ev_key_drop,
  output logic                  ev_belt_cancel
);
  import belt_pkg::*;

  always_comb begin
    state_d        = state_q;
    hold_d         = state_is_hold;
    ev_start       = 1'b0;
    ev_grace_done  = 1'b0;
    ev_alarm_done  = 1'b0;
    ev_key_drop    = 1'b0;
    ev_belt_cancel = 1'b0;
    case (state_q)
      ST_OFF: begin
        if (!key_on) begin
          hold_d = 1'b0;
        end else if (!state_is_hold) begin
          state_d  = ST_WAIT;
          ev_start = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!key_on) begin
          state_d     = ST_OFF;
          hold_d      = 1'b0;
          ev_key_drop = 1'b1;
        end else if (belt_fastened) begin
          state_d        = ST_OFF;
          hold_d         = 1'b1;
          ev_belt_cancel = 1'b1;
        end else if (window_done) begin
          state_d       = ST_ALARM;
          ev_grace_done = 1'b1;
        end
      end
      ST_ALARM: begin
        if (!key_on) begin
          state_d     = ST_OFF;
          hold_d      = 1'b0;
          ev_key_drop = 1'b1;
        end else if (belt_fastened) begin
          state_d        = ST_OFF;
          hold_d         = 1'b1;
          ev_belt_cancel = 1'b1;
        end else if (window_done) begin
          state_d       = ST_OFF;
          hold_d        = 1'b1;
          ev_alarm_done = 1'b1;
        end
      end
      default: begin
        state_d = ST_OFF;
        hold_d  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/belt_chime_ctrl.sv
module belt_chime_ctrl #(
  parameter int GRACE_SEC = 5,
  parameter int ALARM_SEC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic key_on,
  input  logic belt_fastened,
  input  logic sec_tick,
  output logic alarm_en,
  output logic timer_start
);
  import belt_pkg::*;

  localparam int MAX_SEC = (GRACE_SEC > ALARM_SEC) ? GRACE_SEC : ALARM_SEC;
  localparam int CW      = $clog2(MAX_SEC + 1);

  belt_state_e state_q, state_d;
  logic        hold_q, hold_d;
  logic        start_q;
  logic        window_done;
  logic [15:0] limit;
  logic        ev_start, ev_grace_done, ev_alarm_done, ev_key_drop, ev_belt_cancel;
  logic        count_clr;

  assign limit     = (state_q == ST_ALARM) ? 16'(ALARM_SEC) : 16'(GRACE_SEC);
  assign count_clr = (state_d != state_q) || (state_q == ST_OFF);

  belt_sec_counter #(.CW(CW)) u_count (
    .clk   (clk),
    .rst   (rst),
    .clr   (count_clr),
    .tick  (sec_tick),
    .limit (limit),
    .done  (window_done)
  );

  belt_fsm u_fsm (
    .state_is_hold  (hold_q),
    .state_q        (state_q),
    .key_on         (key_on),
    .belt_fastened  (belt_fastened),
    .window_done    (window_done),
    .state_d        (state_d),
    .hold_d         (hold_d),
    .ev_start       (ev_start),
    .ev_grace_done  (ev_grace_done),
    .ev_alarm_done  (ev_alarm_done),
    .ev_key_drop    (ev_key_drop),
    .ev_belt_cancel (ev_belt_cancel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      hold_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      start_q <= ev_start;
    end
  end

  assign alarm_en    = (state_q == ST_ALARM);
  assign timer_start = start_q;
endmodule

// File: rtl/belt_chime_checker.sv
module belt_chime_checker (
  input logic clk,
  input logic rst,
  input logic key_on,
  input logic belt_fastened,
  input logic sec_tick,
  input logic alarm_en,
  input logic timer_start,
  input logic ev_grace_done,
  input logic ev_alarm_done,
  input logic ev_key_drop,
  input logic ev_belt_cancel
);
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    timer_start |=> !timer_start);
  p_strobe_needs_key_r2: assert property (@(posedge clk) disable iff (rst)
    timer_start |-> $past(key_on));
  p_grace_raises_alarm_r3: assert property (@(posedge clk) disable iff (rst)
    ev_grace_done |=> alarm_en);
  p_belt_stops_alarm_r5: assert property (@(posedge clk) disable iff (rst)
    (alarm_en && belt_fastened) |=> !alarm_en);
  p_key_stops_alarm_r6: assert property (@(posedge clk) disable iff (rst)
    !key_on |=> (!alarm_en && !timer_start));
  p_timeout_ends_alarm_r7: assert property (@(posedge clk) disable iff (rst)
    ev_alarm_done |=> !alarm_en);
  p_drop_or_cancel_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (ev_key_drop || ev_belt_cancel) |=> (!alarm_en && !timer_start));
  p_alarm_after_tick_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_en) |-> $past(sec_tick));
  p_exclusive_outputs_r12: assert property (@(posedge clk) disable iff (rst)
    !(alarm_en && timer_start));
endmodule

bind belt_chime_ctrl belt_chime_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .key_on         (key_on),
  .belt_fastened  (belt_fastened),
  .sec_tick       (sec_tick),
  .alarm_en       (alarm_en),
  .timer_start    (timer_start),
  .ev_grace_done  (ev_grace_done),
  .ev_alarm_done  (ev_alarm_done),
  .ev_key_drop    (ev_key_drop),
  .ev_belt_cancel (ev_belt_cancel)
);

// File: tb/belt_chime_ctrl_bench.sv
`timescale 1ns/1ps
module belt_chime_ctrl_bench;
  localparam int GRACE = 5;
  localparam int ALARM = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_on = 1'b0;
  logic belt_fastened = 1'b0;
  logic sec_tick = 1'b0;
  logic alarm_en, timer_start;

  int n_checks = 0;
  int n_fail   = 0;
  int n_overlap = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  belt_chime_ctrl #(.GRACE_SEC(GRACE), .ALARM_SEC(ALARM)) u_belt_chime_ctrl (
    .clk(clk), .rst(rst), .key_on(key_on), .belt_fastened(belt_fastened),
    .sec_tick(sec_tick), .alarm_en(alarm_en), .timer_start(timer_start)
  );

  always @(negedge clk) if (!rst && alarm_en && timer_start) n_overlap++;

  task automatic chk(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // n seconds pulses, each followed by two quiet cycles; ends on a negedge
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1; step(); sec_tick = 1'b0; step(2);
    end
  endtask

  task automatic go_idle();
    key_on = 1'b0; belt_fastened = 1'b0; sec_tick = 1'b0; step(2);
  endtask

  task automatic key_up_checked(input string req);
    key_on = 1'b1; step();
    chk(timer_start, 1'b1, req);
    step();
    chk(timer_start, 1'b0, req);
  endtask

  task automatic t_reset();
    step(3);
    chk(alarm_en, 1'b0, "R1 alarm in reset");
    chk(timer_start, 1'b0, "R1 strobe in reset");
    rst = 1'b0; step();
    chk(alarm_en, 1'b0, "R1 alarm after reset");
    chk(timer_start, 1'b0, "R1 strobe after reset");
  endtask

  task automatic t_full_cycle();
    go_idle();
    key_up_checked("R2 strobe on key-on");
    ticks(GRACE - 1);
    chk(alarm_en, 1'b0, "R3 before last grace pulse");
    step(20);
    chk(alarm_en, 1'b0, "R9 no pulses no progress");
    ticks(1);
    chk(alarm_en, 1'b1, "R3 alarm after grace");
    ticks(ALARM - 1);
    chk(alarm_en, 1'b1, "R7 alarm still on");
    ticks(1);
    chk(alarm_en, 1'b0, "R7 alarm timed out");
    ticks(GRACE + 3);
    chk(alarm_en, 1'b0, "R10 quiet hold no alarm");
    chk(timer_start, 1'b0, "R10 quiet hold no strobe");
    key_on = 1'b0; step();
    key_up_checked("R10 key cycle restarts");
  endtask

  task automatic t_belt_in_alarm();
    go_idle();
    key_up_checked("R2 strobe");
    ticks(GRACE);
    chk(alarm_en, 1'b1, "R5 setup alarm");
    belt_fastened = 1'b1; step();
    chk(alarm_en, 1'b0, "R5 belt ends alarm");
    belt_fastened = 1'b0; step();
    ticks(GRACE + 1);
    chk(alarm_en, 1'b0, "R10 hold after belt in alarm");
  endtask

  task automatic t_key_off_alarm();
    go_idle();
    key_up_checked("R2 strobe");
    ticks(GRACE);
    chk(alarm_en, 1'b1, "R6 setup alarm");
    key_on = 1'b0; step();
    chk(alarm_en, 1'b0, "R6 key-off ends alarm");
  endtask

  task automatic t_key_off_wait();
    go_idle();
    key_up_checked("R2 strobe");
    ticks(3);
    key_on = 1'b0; step();
    ticks(GRACE + 1);
    chk(alarm_en, 1'b0, "R4 no alarm after key-off");
    key_up_checked("R4 new strobe");
    ticks(GRACE - 1);
    chk(alarm_en, 1'b0, "R9 count restarted");
    ticks(1);
    chk(alarm_en, 1'b1, "R9 full grace after restart");
  endtask

  task automatic t_belt_in_wait();
    go_idle();
    key_up_checked("R2 strobe");
    ticks(2);
    belt_fastened = 1'b1; step();
    belt_fastened = 1'b0; step();
    chk(timer_start, 1'b0, "R8 no strobe on unfasten");
    ticks(GRACE + 3);
    chk(alarm_en, 1'b0, "R8 cancelled no alarm");
    chk(timer_start, 1'b0, "R8 no strobe later");
  endtask

  task automatic t_same_cycle();
    go_idle();
    key_up_checked("R2 strobe");
    ticks(GRACE - 1);
    key_on = 1'b0; sec_tick = 1'b1; step();
    sec_tick = 1'b0;
    chk(alarm_en, 1'b0, "R11 key-off wins");
    ticks(2);
    chk(alarm_en, 1'b0, "R11 stays off");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_cycle();
    t_belt_in_alarm();
    t_key_off_alarm();
    t_key_off_wait();
    t_belt_in_wait();
    t_same_cycle();
    n_checks++;
    if (n_overlap != 0) begin
      n_fail++;
      $display("FAIL R12 overlap cycles: actual %0d expected 0", n_overlap);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule